// File: doc/BRIEF.md
# SCL Period Timebase

This block sets the timing of the serial clock for an I2C master. The input clock first passes through a prescaler, which gives a slower module clock that is meant to run between 7 and 12 MHz. The serial clock then spends one programmable number of module clocks low and another programmable number high. Each of the two counts gets a fixed extra offset, and the size of that offset depends on the prescaler setting. The transfer engine uses the strobes the block produces: one at each falling edge of the serial clock, one at each rising edge, and one in the middle of the high phase so that the data line can be sampled there.

The block runs only while its enable input is high. The controller drives that input when it is out of reset. While the enable is low the serial clock rests high, all counters are at zero and no strobe fires. When the enable rises, the first period starts at once with a low phase. The three setting inputs are copied into working registers at the start of every period. A change made while the block is running therefore takes effect at the next period boundary and never in the middle of a period.

Top module: `scl_timebase`

## Requirements
- R1: While `run_en` is low, `scl_o` is 1 and `fall_stb`, `rise_stb` and `mid_stb` are 0 one cycle later, whatever the setting inputs do.
- R2: The per-phase offset d is 7 when `cfg_pre` is 0, 6 when it is 1, and 5 when it is 2 or more.
- R3: The low phase lasts (`cfg_low` + d) × (`cfg_pre` + 1) input clock cycles.
- R4: The high phase lasts (`cfg_high` + d) × (`cfg_pre` + 1) input clock cycles. A full period is therefore (`cfg_pre`+1) × ((`cfg_low`+d) + (`cfg_high`+d)) cycles.
- R5: In the first cycle after `run_en` rises (one register stage), `scl_o` is 0 and `fall_stb` is 1, so each run begins with a low phase.
- R6: `mid_stb` pulses for one cycle exactly floor((`cfg_high`+d)/2) × (`cfg_pre`+1) cycles after the rising edge of `scl_o`.
- R7: The setting inputs are copied only at a period boundary, which is the start of a run or the end of a high phase. A change made in the middle of a period leaves that period unchanged and applies from the next one.
- R8: At most one strobe is high in any cycle. `fall_stb` is high only in the first cycle of a low level of `scl_o`, and `rise_stb` only in the first cycle of a high level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_en | input | 1 | High while the controller is out of reset |
| cfg_pre | input | PSC_W (8) | Prescaler setting; the module clock is the input clock divided by cfg_pre+1 |
| cfg_low | input | REG_W (16) | Low-phase count before the offset is added |
| cfg_high | input | REG_W (16) | High-phase count before the offset is added |
| scl_o | output | 1 | Serial clock level |
| fall_stb | output | 1 | One-cycle pulse when a low phase starts |
| rise_stb | output | 1 | One-cycle pulse when a high phase starts |
| mid_stb | output | 1 | One-cycle pulse in the middle of the high phase |

## Verification
The block is run with prescaler values of 0, 1 and 3. Each of these selects a different offset, so a wrong offset shows up as a strobe that fires on the wrong cycle. The low and high counts are chosen so that the two phases have different lengths, which catches a design that swaps them. One high length is odd, which tests the rounding of the mid-phase point. One run changes its settings in the middle of its first period: the old settings must still hold up to the period boundary, and only the next period may use the new ones. Between runs the settings are changed while the enable is low, and the serial clock must stay high with no strobe at all.

// File: rtl/scl_timebase_pkg.sv
package scl_timebase_pkg;

  typedef enum logic {PH_LOW = 1'b0, PH_HIGH = 1'b1} scl_phase_e;

  // fixed extra module clocks added to each phase, chosen by prescaler
  function automatic int unsigned phase_offset(input int unsigned pre);
    if (pre == 0) return 7;
    if (pre == 1) return 6;
    return 5;
  endfunction

  // mid-high sampling point, in module clocks after the rising edge
  function automatic int unsigned mid_point(input int unsigned high_len);
    return high_len >> 1;
  endfunction

endpackage

// File: rtl/scl_timebase_shadow.sv
module scl_timebase_shadow #(
  parameter int REG_W = 16,
  parameter int PSC_W = 8,
  parameter int CNT_W = REG_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PSC_W-1:0] cfg_pre,
  input  logic [REG_W-1:0] cfg_low,
  input  logic [REG_W-1:0] cfg_high,
  output logic [PSC_W-1:0] pre_q,
  output logic [CNT_W-1:0] low_len,
  output logic [CNT_W-1:0] high_len
);
  import scl_timebase_pkg::*;

  logic [CNT_W-1:0] ofs_n;
  logic [CNT_W-1:0] low_n;
  logic [CNT_W-1:0] high_n;

  always_comb begin
    ofs_n  = CNT_W'(phase_offset(int'(cfg_pre)));
    low_n  = CNT_W'(cfg_low) + ofs_n;
    high_n = CNT_W'(cfg_high) + ofs_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q    <= '0;
      low_len  <= CNT_W'(7);
      high_len <= CNT_W'(7);
    end else if (load) begin
      pre_q    <= cfg_pre;
      low_len  <= low_n;
      high_len <= high_n;
    end
  end

endmodule

// File: rtl/scl_timebase_prescale.sv
module scl_timebase_prescale #(
  parameter int PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             running,
  input  logic [PSC_W-1:0] pre_q,
  output logic             tick
);
  logic [PSC_W-1:0] div_cnt;

  assign tick = running && (div_cnt == pre_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      div_cnt <= '0;
    else if (clear)  div_cnt <= '0;
    else if (tick)   div_cnt <= '0;
    else if (running) div_cnt <= div_cnt + 1'b1;
  end

endmodule

// File: rtl/scl_timebase_phase.sv
module scl_timebase_phase #(
  parameter int CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             start,
  input  logic             running,
  input  logic             tick,
  input  logic [CNT_W-1:0] low_len,
  input  logic [CNT_W-1:0] high_len,
  output logic             scl_o,
  output logic             fall_stb,
  output logic             rise_stb,
  output logic             mid_stb,
  output logic             period_end
);
  import scl_timebase_pkg::*;

  scl_phase_e       phase;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cur_len;
  logic [CNT_W-1:0] half_len;
  logic             phase_end;
  logic             mid_hit;

  always_comb begin
    cur_len    = (phase == PH_LOW) ? low_len : high_len;
    half_len   = CNT_W'(mid_point(int'(high_len)));
    phase_end  = running && tick && (cnt == cur_len - 1'b1);
    period_end = phase_end && (phase == PH_HIGH);
    mid_hit    = running && tick && (phase == PH_HIGH) && (cnt == half_len - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_HIGH;
      cnt      <= '0;
      scl_o    <= 1'b1;
      fall_stb <= 1'b0;
      rise_stb <= 1'b0;
      mid_stb  <= 1'b0;
    end else if (!run_en) begin
      phase    <= PH_HIGH;
      cnt      <= '0;
      scl_o    <= 1'b1;
      fall_stb <= 1'b0;
      rise_stb <= 1'b0;
      mid_stb  <= 1'b0;
    end else begin
      fall_stb <= 1'b0;
      rise_stb <= 1'b0;
      mid_stb  <= mid_hit;
      if (start) begin
        phase    <= PH_LOW;
        cnt      <= '0;
        scl_o    <= 1'b0;
        fall_stb <= 1'b1;
      end else if (phase_end) begin
        cnt <= '0;
        if (phase == PH_LOW) begin
          phase    <= PH_HIGH;
          scl_o    <= 1'b1;
          rise_stb <= 1'b1;
        end else begin
          phase    <= PH_LOW;
          scl_o    <= 1'b0;
          fall_stb <= 1'b1;
        end
      end else if (tick) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/scl_timebase.sv
module scl_timebase #(
  parameter int REG_W = 16,
  parameter int PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic [PSC_W-1:0] cfg_pre,
  input  logic [REG_W-1:0] cfg_low,
  input  logic [REG_W-1:0] cfg_high,
  output logic             scl_o,
  output logic             fall_stb,
  output logic             rise_stb,
  output logic             mid_stb
);
  localparam int CNT_W = REG_W + 1;

  logic             active;
  logic             start;
  logic             tick;
  logic             period_end;
  logic             load;
  logic [PSC_W-1:0] pre_q;
  logic [CNT_W-1:0] low_len;
  logic [CNT_W-1:0] high_len;

  assign start = run_en && !active;
  assign load  = start || period_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active <= 1'b0;
    else        active <= run_en;
  end

  scl_timebase_shadow #(.REG_W(REG_W), .PSC_W(PSC_W), .CNT_W(CNT_W)) u_shadow (
    .clk(clk), .rst_n(rst_n), .load(load),
    .cfg_pre(cfg_pre), .cfg_low(cfg_low), .cfg_high(cfg_high),
    .pre_q(pre_q), .low_len(low_len), .high_len(high_len)
  );

  scl_timebase_prescale #(.PSC_W(PSC_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .clear(!run_en || start),
    .running(active), .pre_q(pre_q), .tick(tick)
  );

  scl_timebase_phase #(.CNT_W(CNT_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .start(start),
    .running(active), .tick(tick), .low_len(low_len), .high_len(high_len),
    .scl_o(scl_o), .fall_stb(fall_stb), .rise_stb(rise_stb),
    .mid_stb(mid_stb), .period_end(period_end)
  );

endmodule

// File: rtl/scl_timebase_chk.sv
module scl_timebase_chk #(
  parameter int CNT_W = 17
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_en,
  input logic             active,
  input logic             tick,
  input logic             period_end,
  input logic             scl_o,
  input logic             fall_stb,
  input logic             rise_stb,
  input logic             mid_stb,
  input logic [CNT_W-1:0] low_len,
  input logic [CNT_W-1:0] high_len
);

  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (scl_o && !fall_stb && !rise_stb && !mid_stb));

  p_start_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !active) |=> (!scl_o && fall_stb));

  // R3 / R4: the level only moves on a module-clock tick
  p_move_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && active && !tick) |=> $stable(scl_o));

  p_strobe_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fall_stb, rise_stb, mid_stb}));

  p_fall_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb |-> (!scl_o && $past(scl_o)));

  p_rise_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |-> (scl_o && !$past(scl_o)));

  p_mid_in_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mid_stb |-> (scl_o && $past(scl_o)));

  p_cfg_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && active && !period_end) |=> ($stable(low_len) && $stable(high_len)));

endmodule

bind scl_timebase scl_timebase_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_en(run_en), .active(active), .tick(tick),
  .period_end(period_end), .scl_o(scl_o), .fall_stb(fall_stb),
  .rise_stb(rise_stb), .mid_stb(mid_stb), .low_len(low_len), .high_len(high_len)
);

// File: tb/scl_timebase_tb.sv
module scl_timebase_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_en = 1'b0;
  logic [7:0]  cfg_pre = '0;
  logic [15:0] cfg_low = '0;
  logic [15:0] cfg_high = '0;
  logic        scl_o, fall_stb, rise_stb, mid_stb;

  int     checks = 0;
  int     failures = 0;
  longint cyc = 0;
  bit     done = 1'b0;

  int     kq[$];
  longint tq[$];
  string  sq[$];

  always #2.5 clk = ~clk;

  scl_timebase u_dut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .cfg_pre(cfg_pre),
    .cfg_low(cfg_low), .cfg_high(cfg_high), .scl_o(scl_o),
    .fall_stb(fall_stb), .rise_stb(rise_stb), .mid_stb(mid_stb)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // R2: offset per prescaler setting
  function automatic int offs(input int p);
    case (p)
      0:       return 7;
      1:       return 6;
      default: return 5;
    endcase
  endfunction

  // driver: queue expected strobes (kind 0 fall, 1 rise, 2 mid)
  task automatic push_periods(input int p, input int lo, input int hi, input int n,
                              input longint s, input string tag, output longint nxt);
    longint t = s;
    int lcyc = (lo + offs(p)) * (p + 1);
    int hcyc = (hi + offs(p)) * (p + 1);
    int mcyc = ((hi + offs(p)) / 2) * (p + 1);
    for (int i = 0; i < n; i++) begin
      kq.push_back(0); tq.push_back(t);               sq.push_back({tag, " fall R5/R4"});
      kq.push_back(1); tq.push_back(t + lcyc);        sq.push_back({tag, " rise R2/R3"});
      kq.push_back(2); tq.push_back(t + lcyc + mcyc); sq.push_back({tag, " mid R6"});
      t = t + lcyc + hcyc;
    end
    nxt = t;
  endtask

  // monitor: pop and compare
  int     mk, ek, nst;
  longint et;
  string  etag;
  always @(negedge clk) begin
    if (rst_n) begin
      nst = int'(fall_stb) + int'(rise_stb) + int'(mid_stb);
      if (nst > 1) chk(1'b0, "R8 strobes overlap", nst, 1);
      else if (nst == 1) begin
        mk = fall_stb ? 0 : (rise_stb ? 1 : 2);
        chk(mk == 0 ? !scl_o : scl_o, "R8 level at strobe", scl_o, mk == 0 ? 0 : 1);
        if (kq.size() == 0) chk(1'b0, "R8 unexpected strobe kind", mk, -1);
        else begin
          ek = kq.pop_front(); et = tq.pop_front(); etag = sq.pop_front();
          chk(mk == ek, {etag, " kind"}, mk, ek);
          chk(cyc == et, {etag, " cycle"}, cyc, et);
        end
      end
    end
  end

  task automatic run_cfg(input int p, input int lo, input int hi, input int n, input string tag);
    longint nx;
    @(negedge clk);
    cfg_pre = 8'(p); cfg_low = 16'(lo); cfg_high = 16'(hi);
    run_en = 1'b1;
    push_periods(p, lo, hi, n, cyc + 1, tag, nx);
    wait (kq.size() == 0);
    @(negedge clk);
    run_en = 1'b0;
  endtask

  task automatic idle_check(input int n);
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      cfg_pre = 8'(i); cfg_low = 16'(i * 3); cfg_high = 16'(i + 1);
      @(negedge clk);
      chk(scl_o == 1'b1, "R1 idle scl", scl_o, 1);
      chk(!fall_stb && !rise_stb && !mid_stb, "R1 idle strobes",
          {fall_stb, rise_stb, mid_stb}, 0);
    end
  endtask

  initial begin
    longint nx;
    repeat (3) @(negedge clk);
    chk(scl_o == 1'b1, "R1 reset scl", scl_o, 1);
    rst_n = 1'b1;
    idle_check(4);

    run_cfg(0, 3, 2, 2, "p0");   // d=7
    idle_check(3);
    run_cfg(1, 0, 0, 2, "p1");   // d=6
    idle_check(3);
    run_cfg(3, 1, 4, 2, "p3");   // d=5, odd high length
    idle_check(3);
    run_cfg(2, 2, 1, 1, "p2");

    // R7: change settings during the first period
    idle_check(2);
    @(negedge clk);
    cfg_pre = 8'd0; cfg_low = 16'd2; cfg_high = 16'd3;
    run_en = 1'b1;
    push_periods(0, 2, 3, 1, cyc + 1, "R7 old", nx);
    push_periods(1, 4, 1, 2, nx, "R7 new", nx);
    repeat (3) @(negedge clk);
    cfg_pre = 8'd1; cfg_low = 16'd4; cfg_high = 16'd1;
    wait (kq.size() == 0);
    @(negedge clk);
    run_en = 1'b0;
    idle_check(20);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog R5 actual=%0d expected=%0d", kq.size(), 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule